// File: doc/BRIEF.md
# Two-Tone FSK Proximity Tag Waveform Generator

This block produces the coil-modulation sample stream for a low-frequency proximity tag that signals with two sub-carrier frequencies. It is given a 44-bit identifier, split into a high part and a 32-bit low part. A start pulse launches transmission. After that, the block emits one modulation level for every strobe that marks a carrier cycle. A high level opens the coil and a low level shorts it.

The frame is generated on the fly from counters, so no sample memory is needed. A frame opens with a single short fc/8 cycle and then a start marker. The marker is made of eight sub-carrier groups that do not form legal data symbols. The identifier bits follow, most significant first. Each bit is a pair of groups, one fc/8 and one fc/10, and the order of the pair gives the bit value. A single fc/8 cycle precedes every group of four bits.

Frames repeat back to back until a stop request. An identifier whose high part needs more than 12 bits is refused and nothing is sent. The identifier is captured when transmission starts.

Top module: `fsk_tag_wavegen`

## Requirements
- R1: After reset, `mod_o`, `busy_o` and `id_err_o` are all 0.
- R2: An fc/8 cycle is the 8 samples 1,1,0,0,0,0,0,0. An fc/8 group is 6 consecutive such cycles (48 samples).
- R3: An fc/10 cycle is the 10 samples 1,1,1,0,0,0,0,0,0,0. An fc/10 group is 5 consecutive such cycles (50 samples).
- R4: Identifier bits are sent from bit 43 down to bit 0. A 1 is an fc/10 group followed by an fc/8 group. A 0 is an fc/8 group followed by an fc/10 group.
- R5: One lone fc/8 cycle (8 samples) comes before the start marker and before each of bits 43, 39, 35, …, 3.
- R6: The start marker follows the leading lone cycle. It is the groups fc/8, fc/8, fc/8, fc/10, fc/10, fc/10, fc/8, fc/10, in that order.
- R7: A frame is 4800 samples long. Sample 4800 onward repeats the frame from sample 0, with no gap.
- R8: While busy, each strobe cycle on `carr_stb_i` moves `mod_o` to the next sample, one cycle after the strobe. Without a strobe, `mod_o` holds its value.
- R9: A start while idle with `id_hi_i` > 0xFFF is refused. `busy_o` stays 0, `mod_o` stays 0 and `id_err_o` becomes 1. The next accepted start clears `id_err_o`.
- R10: A start while idle with a legal identifier raises `busy_o` on the next cycle. `stop_i` has priority over everything else: on the next cycle `busy_o` and `mod_o` are 0. The first strobe after an accepted start outputs frame sample 0.
- R11: The identifier is latched at the accepted start. Changes to the id inputs, and further start pulses while busy, have no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, acted on only when idle |
| stop_i | input | 1 | Stop request, returns the block to idle |
| carr_stb_i | input | 1 | One-cycle strobe per carrier cycle |
| id_hi_i | input | 16 | Identifier high part, legal range 0 to 0xFFF |
| id_lo_i | input | 32 | Identifier low part |
| mod_o | output | 1 | Modulation level: 1 opens coil, 0 shorts coil |
| busy_o | output | 1 | High while transmitting |
| id_err_o | output | 1 | Set by a refused start, cleared by an accepted one |

## Verification
The bench targets four transitions where the stream can go wrong:
- Marker to data. A wrong marker order, or a missing leading lone cycle, would shift every later sample by 8 or more positions.
- Nibble boundary. Misplacing the lone cycle by one bit would move it to bits 42, 38, and so on.
- Last bit into the next frame. An off-by-one wrap would add a gap sample or drop the final sample of bit 0.
- Strobe gaps. A design that advances on the clock instead of the strobe would run ahead of the carrier.

Refusal is checked with a high part of 0x1ABC, which a design truncating to 12 bits would wrongly accept. Boundary acceptance is checked at exactly 0xFFF. A start during transmission, sent together with new id values, must leave the stream unchanged; a design that does not latch the identifier would corrupt the bits still to come.

// File: rtl/fsk_wave_pkg.sv
package fsk_wave_pkg;

   // position of the sequencer inside one frame
   typedef enum logic [2:0] {
      PH_LEAD  = 3'd0,   // lone cycle ahead of the start marker
      PH_SOF   = 3'd1,   // start marker groups
      PH_NIB   = 3'd2,   // lone cycle ahead of a nibble
      PH_BIT_A = 3'd3,   // first group of a data bit
      PH_BIT_B = 3'd4    // second group of a data bit
   } fsk_phase_e;

   // sub-carrier selection
   typedef enum logic {
      BURST_F8  = 1'b0,
      BURST_F10 = 1'b1
   } fsk_burst_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fsk_burst_gen.sv
module fsk_burst_gen
   import fsk_wave_pkg::*;
#(
   parameter int unsigned F8_PER   = 8,
   parameter int unsigned F8_HIGH  = 2,
   parameter int unsigned F8_REPS  = 6,
   parameter int unsigned F10_PER  = 10,
   parameter int unsigned F10_HIGH = 3,
   parameter int unsigned F10_REPS = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic       adv_i,
   input  fsk_burst_e kind_i,
   input  logic       lone_i,
   output logic       level_o,
   output logic       seg_last_o
);

   localparam int unsigned PER_MAX = max2(F8_PER, F10_PER);
   localparam int unsigned REP_MAX = max2(F8_REPS, F10_REPS);
   localparam int unsigned SW      = $clog2(PER_MAX + 1);
   localparam int unsigned CW      = $clog2(REP_MAX + 1);

   localparam logic [SW-1:0] F8_LAST   = SW'(F8_PER - 1);
   localparam logic [SW-1:0] F10_LAST  = SW'(F10_PER - 1);
   localparam logic [SW-1:0] F8_HLEN   = SW'(F8_HIGH);
   localparam logic [SW-1:0] F10_HLEN  = SW'(F10_HIGH);
   localparam logic [CW-1:0] F8_RLAST  = CW'(F8_REPS - 1);
   localparam logic [CW-1:0] F10_RLAST = CW'(F10_REPS - 1);

   generate
      if (F8_HIGH == 0 || F8_HIGH >= F8_PER) begin : g_bad_f8
         $error("fsk_burst_gen: F8_HIGH must lie in 1..F8_PER-1");
      end
      if (F10_HIGH == 0 || F10_HIGH >= F10_PER) begin : g_bad_f10
         $error("fsk_burst_gen: F10_HIGH must lie in 1..F10_PER-1");
      end
      if (F8_REPS == 0 || F10_REPS == 0) begin : g_bad_reps
         $error("fsk_burst_gen: group repeat counts must be non-zero");
      end
   endgenerate

   logic [SW-1:0] samp_q;
   logic [CW-1:0] cyc_q;
   logic [SW-1:0] per_last;
   logic [SW-1:0] high_len;
   logic [CW-1:0] rep_last;
   logic          cyc_end;

   always_comb begin
      if (kind_i == BURST_F10) begin
         per_last = F10_LAST;
         high_len = F10_HLEN;
         rep_last = F10_RLAST;
      end else begin
         per_last = F8_LAST;
         high_len = F8_HLEN;
         rep_last = F8_RLAST;
      end
      if (lone_i) begin
         rep_last = '0;
      end
   end

   assign level_o    = (samp_q < high_len);
   assign cyc_end    = (samp_q == per_last);
   assign seg_last_o = cyc_end && (cyc_q == rep_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_q <= '0;
         cyc_q  <= '0;
      end else if (clr_i) begin
         samp_q <= '0;
         cyc_q  <= '0;
      end else if (adv_i) begin
         if (cyc_end) begin
            samp_q <= '0;
            if (seg_last_o) begin
               cyc_q <= '0;
            end else begin
               cyc_q <= cyc_q + 1'b1;
            end
         end else begin
            samp_q <= samp_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq
   import fsk_wave_pkg::*;
#(
   parameter int unsigned          ID_W     = 44,
   parameter int unsigned          NIB_W    = 4,
   parameter int unsigned          SOF_LEN  = 8,
   parameter logic [SOF_LEN-1:0]   SOF_MASK = 8'b1011_1000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_i,
   input  logic            step_i,
   input  logic [ID_W-1:0] id_i,
   output fsk_burst_e      kind_o,
   output logic            lone_o
);

   localparam int unsigned BW = $clog2(ID_W);
   localparam int unsigned XW = (SOF_LEN > 1) ? $clog2(SOF_LEN) : 1;

   localparam logic [BW-1:0] TOP_BIT  = BW'(ID_W - 1);
   localparam logic [BW-1:0] NIB_MASK = BW'(NIB_W - 1);
   localparam logic [XW-1:0] SOF_LAST = XW'(SOF_LEN - 1);

   generate
      if ((NIB_W & (NIB_W - 1)) != 0) begin : g_bad_nib
         $error("fsk_frame_seq: NIB_W must be a power of two");
      end
      if ((ID_W % NIB_W) != 0) begin : g_bad_idw
         $error("fsk_frame_seq: ID_W must be a multiple of NIB_W");
      end
   endgenerate

   fsk_phase_e    phase_q;
   logic [XW-1:0] sof_q;
   logic [BW-1:0] bit_q;
   logic          cur_bit;
   logic [BW-1:0] next_bit;
   logic          nib_edge;

   assign cur_bit  = id_i[bit_q];
   assign next_bit = bit_q - 1'b1;
   assign nib_edge = ((next_bit & NIB_MASK) == NIB_MASK);

   always_comb begin
      kind_o = BURST_F8;
      lone_o = 1'b0;
      case (phase_q)
         PH_LEAD, PH_NIB: begin
            kind_o = BURST_F8;
            lone_o = 1'b1;
         end
         PH_SOF:   kind_o = SOF_MASK[sof_q] ? BURST_F10 : BURST_F8;
         PH_BIT_A: kind_o = cur_bit ? BURST_F10 : BURST_F8;
         PH_BIT_B: kind_o = cur_bit ? BURST_F8  : BURST_F10;
         default:  kind_o = BURST_F8;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_LEAD;
         sof_q   <= '0;
         bit_q   <= TOP_BIT;
      end else if (clr_i) begin
         phase_q <= PH_LEAD;
         sof_q   <= '0;
         bit_q   <= TOP_BIT;
      end else if (step_i) begin
         case (phase_q)
            PH_LEAD: begin
               phase_q <= PH_SOF;
               sof_q   <= '0;
            end
            PH_SOF: begin
               if (sof_q == SOF_LAST) begin
                  phase_q <= PH_NIB;
                  bit_q   <= TOP_BIT;
               end else begin
                  sof_q <= sof_q + 1'b1;
               end
            end
            PH_NIB:   phase_q <= PH_BIT_A;
            PH_BIT_A: phase_q <= PH_BIT_B;
            PH_BIT_B: begin
               if (bit_q == '0) begin
                  phase_q <= PH_LEAD;
               end else begin
                  bit_q   <= next_bit;
                  phase_q <= nib_edge ? PH_NIB : PH_BIT_A;
               end
            end
            default: phase_q <= PH_LEAD;
         endcase
      end
   end

endmodule

// File: rtl/fsk_tag_wavegen.sv
module fsk_tag_wavegen
   import fsk_wave_pkg::*;
#(
   parameter int unsigned        HI_IN_W  = 16,
   parameter int unsigned        HI_W     = 12,
   parameter int unsigned        LO_W     = 32,
   parameter int unsigned        NIB_W    = 4,
   parameter int unsigned        SOF_LEN  = 8,
   parameter logic [SOF_LEN-1:0] SOF_MASK = 8'b1011_1000,
   parameter int unsigned        F8_PER   = 8,
   parameter int unsigned        F8_HIGH  = 2,
   parameter int unsigned        F8_REPS  = 6,
   parameter int unsigned        F10_PER  = 10,
   parameter int unsigned        F10_HIGH = 3,
   parameter int unsigned        F10_REPS = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               stop_i,
   input  logic               carr_stb_i,
   input  logic [HI_IN_W-1:0] id_hi_i,
   input  logic [LO_W-1:0]    id_lo_i,
   output logic               mod_o,
   output logic               busy_o,
   output logic               id_err_o
);

   localparam int unsigned ID_W = HI_W + LO_W;

   generate
      if (HI_IN_W < HI_W) begin : g_bad_hi
         $error("fsk_tag_wavegen: HI_IN_W must be at least HI_W");
      end
   endgenerate

   logic            id_ok;
   logic            busy_q;
   logic            err_q;
   logic            mod_q;
   logic [ID_W-1:0] id_q;
   logic            req;
   logic            go;
   logic            refuse;
   logic            adv;
   logic            clr;
   logic            level;
   logic            seg_last;
   fsk_burst_e      kind;
   logic            lone;

   // range check only exists when the input is wider than the legal field
   generate
      if (HI_IN_W > HI_W) begin : g_range_chk
         assign id_ok = ~|id_hi_i[HI_IN_W-1:HI_W];
      end else begin : g_no_range_chk
         assign id_ok = 1'b1;
      end
   endgenerate

   assign req    = start_i & ~busy_q & ~stop_i;
   assign go     = req & id_ok;
   assign refuse = req & ~id_ok;
   assign adv    = busy_q & carr_stb_i & ~stop_i;
   assign clr    = go | stop_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_q <= '0;
      end else if (go) begin
         id_q <= {id_hi_i[HI_W-1:0], id_lo_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         err_q  <= 1'b0;
         mod_q  <= 1'b0;
      end else begin
         if (stop_i) begin
            busy_q <= 1'b0;
         end else if (go) begin
            busy_q <= 1'b1;
         end

         if (refuse) begin
            err_q <= 1'b1;
         end else if (go) begin
            err_q <= 1'b0;
         end

         if (stop_i) begin
            mod_q <= 1'b0;
         end else if (adv) begin
            mod_q <= level;
         end
      end
   end

   fsk_frame_seq #(
      .ID_W     (ID_W),
      .NIB_W    (NIB_W),
      .SOF_LEN  (SOF_LEN),
      .SOF_MASK (SOF_MASK)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr),
      .step_i (adv & seg_last),
      .id_i   (id_q),
      .kind_o (kind),
      .lone_o (lone)
   );

   fsk_burst_gen #(
      .F8_PER   (F8_PER),
      .F8_HIGH  (F8_HIGH),
      .F8_REPS  (F8_REPS),
      .F10_PER  (F10_PER),
      .F10_HIGH (F10_HIGH),
      .F10_REPS (F10_REPS)
   ) u_burst (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr),
      .adv_i      (adv),
      .kind_i     (kind),
      .lone_i     (lone),
      .level_o    (level),
      .seg_last_o (seg_last)
   );

   assign mod_o    = mod_q;
   assign busy_o   = busy_q;
   assign id_err_o = err_q;

endmodule

// File: rtl/fsk_tag_wavegen_chk.sv
module fsk_tag_wavegen_chk #(
   parameter int unsigned HI_IN_W = 16,
   parameter int unsigned HI_W    = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start_i,
   input logic               stop_i,
   input logic               carr_stb_i,
   input logic [HI_IN_W-1:0] id_hi_i,
   input logic               mod_o,
   input logic               busy_o,
   input logic               id_err_o
);

   logic hi_bad;
   assign hi_bad = ((id_hi_i >> HI_W) != '0);

   // R10
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (!busy_o && !mod_o));

   // R8
   strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!carr_stb_i && !stop_i) |=> $stable(mod_o));

   // R9
   refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !stop_i && hi_bad) |=> (!busy_o && id_err_o));

   // R9
   idle_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mod_o);

   // R10
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !stop_i && !hi_bad) |=> (busy_o && !id_err_o));

   // R11
   busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !stop_i) |=> busy_o);

endmodule

bind fsk_tag_wavegen fsk_tag_wavegen_chk #(
   .HI_IN_W (HI_IN_W),
   .HI_W    (HI_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .stop_i     (stop_i),
   .carr_stb_i (carr_stb_i),
   .id_hi_i    (id_hi_i),
   .mod_o      (mod_o),
   .busy_o     (busy_o),
   .id_err_o   (id_err_o)
);

// File: tb/fsk_tag_wavegen_tb.sv
`timescale 1ns/1ps
module fsk_tag_wavegen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        stop_i = 1'b0;
   logic        carr_stb_i = 1'b0;
   logic [15:0] id_hi_i = '0;
   logic [31:0] id_lo_i = '0;
   logic        mod_o;
   logic        busy_o;
   logic        id_err_o;

   always #10 clk = ~clk;   // 50 MHz

   fsk_tag_wavegen u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .stop_i     (stop_i),
      .carr_stb_i (carr_stb_i),
      .id_hi_i    (id_hi_i),
      .id_lo_i    (id_lo_i),
      .mod_o      (mod_o),
      .busy_o     (busy_o),
      .id_err_o   (id_err_o)
   );

   int    n_chk = 0;
   int    n_err = 0;
   string tag = "R1";
   bit    cmp_en = 1'b0;
   bit    cap_en = 1'b0;

   // behavioural reference
   int   frame[$];
   int   cap[$];
   int   m_idx = 0;
   logic m_mod = 1'b0;
   logic m_busy = 1'b0;
   logic m_err = 1'b0;
   bit   m_adv = 1'b0;

   task automatic push_cycles(input int per, input int hi, input int reps);
      for (int r = 0; r < reps; r++)
         for (int s = 0; s < per; s++)
            frame.push_back((s < hi) ? 1 : 0);
   endtask

   task automatic build_frame(input logic [11:0] hi, input logic [31:0] lo);
      logic [43:0] id;
      id = {hi, lo};
      frame.delete();
      push_cycles(8, 2, 1);
      push_cycles(8, 2, 6); push_cycles(8, 2, 6); push_cycles(8, 2, 6);
      push_cycles(10, 3, 5); push_cycles(10, 3, 5); push_cycles(10, 3, 5);
      push_cycles(8, 2, 6); push_cycles(10, 3, 5);
      for (int b = 43; b >= 0; b--) begin
         if ((b % 4) == 3) push_cycles(8, 2, 1);
         if (id[b]) begin
            push_cycles(10, 3, 5); push_cycles(8, 2, 6);
         end else begin
            push_cycles(8, 2, 6); push_cycles(10, 3, 5);
         end
      end
   endtask

   always @(posedge clk) begin
      m_adv = 1'b0;
      if (!rst_n) begin
         m_mod = 1'b0; m_busy = 1'b0; m_err = 1'b0; m_idx = 0;
      end else if (stop_i) begin
         m_busy = 1'b0; m_mod = 1'b0;
      end else if (start_i && !m_busy) begin
         if (id_hi_i > 16'h0FFF) begin
            m_err = 1'b1;
         end else begin
            m_err = 1'b0; m_busy = 1'b1; m_idx = 0;
            build_frame(id_hi_i[11:0], id_lo_i);
         end
      end else if (m_busy && carr_stb_i) begin
         m_mod = frame[m_idx][0];
         m_adv = 1'b1;
         m_idx = (m_idx + 1) % frame.size();
      end
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         n_chk++;
         if (mod_o !== m_mod || busy_o !== m_busy || id_err_o !== m_err) begin
            n_err++;
            $display("FAIL %s: mod/busy/err actual %b%b%b expected %b%b%b",
                     tag, mod_o, busy_o, id_err_o, m_mod, m_busy, m_err);
         end
         if (cap_en && m_adv) cap.push_back(int'(mod_o));
      end
   end

   task automatic check(input bit ok, input string t, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", t, act, exp);
      end
   endtask

   // compare one carrier cycle in the captured stream
   task automatic chk_pat(input int at, input int per, input int hi, input string t);
      int act = 0;
      int exp = 0;
      for (int s = 0; s < per; s++) begin
         exp = (exp << 1) | ((s < hi) ? 1 : 0);
         act = (act << 1) | ((at + s < cap.size()) ? cap[at + s] : 2);
      end
      check(act == exp, t, act, exp);
   endtask

   task automatic cyc(input bit stb, input bit st, input bit sp);
      carr_stb_i = stb; start_i = st; stop_i = sp;
      @(negedge clk);
      carr_stb_i = 1'b0; start_i = 1'b0; stop_i = 1'b0;
   endtask

   task automatic run(input int n, input int mode);
      for (int i = 0; i < n; i++) begin
         if (mode == 0) cyc(1'b1, 1'b0, 1'b0);
         else if (mode == 1) cyc(((i % 3) == 0) || ((i % 7) == 2), 1'b0, 1'b0);
         else cyc(1'b0, 1'b0, 1'b0);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic v;
      int   same;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(mod_o == 0 && busy_o == 0 && id_err_o == 0, "R1",
            {mod_o, busy_o, id_err_o}, 0);
      cmp_en = 1'b1;

      // R9: refused identifier
      tag = "R9";
      id_hi_i = 16'h1ABC; id_lo_i = 32'hFFFF_FFFF;
      cyc(1'b0, 1'b1, 1'b0);
      check(busy_o == 0 && id_err_o == 1, "R9 refuse", {busy_o, id_err_o}, 1);
      run(30, 0);
      check(mod_o == 0 && busy_o == 0, "R9 nothing sent", {mod_o, busy_o}, 0);

      // R10: accepted start, strobe every cycle
      tag = "R10";
      id_hi_i = 16'h0ADC; id_lo_i = 32'h1234_5678;
      cap_en = 1'b1;
      cyc(1'b0, 1'b1, 1'b0);
      check(busy_o == 1 && id_err_o == 0, "R10 accept clears R9 error",
            {busy_o, id_err_o}, 2);
      tag = "R4";
      run(2000, 0);
      // R11: new id and start while busy
      tag = "R11";
      id_hi_i = 16'h0123; id_lo_i = 32'h0;
      cyc(1'b1, 1'b1, 1'b0);
      run(3100, 0);
      cap_en = 1'b0;

      chk_pat(0, 8, 2, "R5 lead lone cycle");
      chk_pat(8, 8, 2, "R2 fc8 cycle");
      chk_pat(48, 8, 2, "R2 sixth fc8 cycle of group");
      chk_pat(152, 10, 3, "R3 fc10 cycle");
      chk_pat(292, 10, 3, "R3 fifth fc10 cycle of group");
      chk_pat(302, 8, 2, "R6 seventh marker group fc8");
      chk_pat(350, 10, 3, "R6 eighth marker group fc10");
      chk_pat(400, 8, 2, "R5 lone before bit 43");
      chk_pat(408, 10, 3, "R4 bit43=1 first half fc10");
      chk_pat(458, 8, 2, "R4 bit43=1 second half fc8");
      chk_pat(506, 8, 2, "R4 bit42=0 first half fc8");
      chk_pat(800, 8, 2, "R5 lone before bit 39");
      chk_pat(808, 10, 3, "R4 bit39=1 first half fc10");
      same = 1;
      for (int k = 0; k < 200; k++)
         if (cap.size() <= 4800 + k || cap[4800 + k] != cap[k]) same = 0;
      // R7 repeat without gap
      check(same == 1, "R7 frame repeat", same, 1);

      // R8: hold with no strobe
      tag = "R8";
      for (int i = 0; i < 20 && mod_o == 0; i++) cyc(1'b1, 1'b0, 1'b0);
      v = mod_o;
      run(25, 2);
      check(mod_o == v && v == 1'b1, "R8 hold without strobe", mod_o, 1);
      run(6000, 1);

      // R10: stop
      tag = "R10";
      cyc(1'b1, 1'b0, 1'b1);
      check(busy_o == 0 && mod_o == 0, "R10 stop", {busy_o, mod_o}, 0);
      run(20, 0);
      check(mod_o == 0, "R10 idle after stop", mod_o, 0);
      id_hi_i = 16'h0FFF; id_lo_i = 32'h0;
      cyc(1'b1, 1'b1, 1'b1);
      check(busy_o == 0, "R10 stop beats start", busy_o, 0);

      // boundary identifier 0xFFF accepted
      tag = "R9";
      cyc(1'b0, 1'b1, 1'b0);
      check(busy_o == 1 && id_err_o == 0, "R9 0xFFF accepted", {busy_o, id_err_o}, 2);
      tag = "R7";
      run(4900, 0);
      run(300, 1);
      cyc(1'b0, 1'b0, 1'b1);
      @(negedge clk);
      finish_run();
   end

endmodule